// File: doc/BRIEF.md
# Serial Frame Transmitter with Data Delay

This block turns a stream of 32-bit words into a single serial data line. It makes its own bit-clock enable by dividing the system clock, and a frame-start pulse that recurs every 32 bit clocks. A data-delay setting of 0, 1 or 2 bit clocks places the first bit of each word that many bit clocks after its frame-start pulse. The frame is never lengthened to make room for the delay. With a delay of D, the last D bits of a word therefore go out during the first D bit clocks of the next frame. The frame-start pulse marks where a word begins; it does not mark a window of valid data.

Words arrive on a valid/ready handshake into a one-word holding buffer, which stands in for a transmit buffer fed by DMA. After reset the transmitter pulls one word per frame with no idle bit clocks, so the line runs at full bandwidth. If the buffer is empty when a word is due, the slot is filled with zeros and a sticky underrun flag is raised. The delay setting is captured only while reset is held.

Top module: `sft_tx`

## Requirements
- R1: `bit_en` is a one-system-cycle pulse every CLK_DIV cycles. The first pulse falls on the CLK_DIV-th rising edge after reset is released. Every other output changes only at the edge that raises `bit_en`.
- R2: `frame_start` is high for exactly one bit period on bit tick 0 and on every 32nd tick after it. This holds for every delay setting.
- R3: With delay code D (0, 1 or 2), the line is 0 for the first D ticks after reset. The most significant bit of the first word appears on tick D. Code 3 behaves as 2.
- R4: Each word is sent most significant bit first, one bit per tick.
- R5: Words follow one another with no gap. Word n occupies ticks 32n+D to 32n+D+31, so with D>0 its last D bits fall after the next frame-start pulse.
- R6: A word is taken when `in_valid` and `in_ready` are both high at a rising edge. Words are sent in the order they were taken. `in_ready` is low in the cycle after a word is taken, while the one-word buffer is full.
- R7: If the buffer is empty when a word is due (tick 32n+D), that slot carries zeros. `underrun` goes high at that tick and stays high until reset.
- R8: Changing `cfg_delay` after reset is released has no effect on the framing or the data.
- R9: While reset is held, `frame_start`, `tx_data`, `underrun`, `bit_en` and `in_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; `cfg_delay` is captured while it is held |
| cfg_delay | input | DLY_W | Data delay code in bit clocks (0, 1, 2; 3 is treated as 2) |
| in_data | input | WORD_W | Word offered for transmission |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding buffer is empty and will take a word |
| bit_en | output | 1 | One-cycle bit-clock enable pulse |
| frame_start | output | 1 | High for one bit period at the start of each frame |
| tx_data | output | 1 | Serial data line, MSB first |
| underrun | output | 1 | Sticky flag: a slot was sent with no word available |

## Verification
Every serial output is registered on the edge that raises `bit_en`. The value for tick k is therefore visible in the very cycle in which `bit_en` is high, and it stays unchanged for the following CLK_DIV-1 cycles. The bench samples on the falling edge. It counts `bit_en` pulses to find the index of the latest tick, and compares `frame_start`, `tx_data` and `underrun` in every cycle against values computed from that index, the delay and the word sequence. The underrun flag is due in the same cycle as tick 32n+D. `in_ready` is due low one edge after a transfer. The expected pulse position of `bit_en` itself is counted from the release of reset.

// File: rtl/sft_pkg.sv
package sft_pkg;
  // Defaults shared by the transmitter and its submodules
  localparam int SFT_WORD_W  = 32;
  localparam int SFT_CLK_DIV = 4;
  localparam int SFT_MAX_DLY = 2;
endpackage

// File: rtl/sft_bitclk.sv
// Divides the system clock into a bit-clock tick strobe.
module sft_bitclk #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == CNT_W'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sft_framer.sv
// Frame position counter, frame-start output and the delay pipeline that
// decides on which tick the next word is loaded.
module sft_framer #(
  parameter int WORD_W  = 32,
  parameter int MAX_DLY = 2,
  parameter int DLY_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [DLY_W-1:0] dly,
  output logic             frame_start,
  output logic             load
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]   fcnt_q;
  logic [MAX_DLY-1:0] hist_q;
  logic               mark_now;
  logic               sel;

  assign mark_now = (fcnt_q == '0);

  // Pick the frame marker delayed by the configured number of ticks
  always_comb begin
    sel = mark_now;
    for (int i = 0; i < MAX_DLY; i++) begin
      if (dly == DLY_W'(i + 1)) sel = hist_q[i];
    end
  end

  assign load = tick && sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_q      <= '0;
      frame_start <= 1'b0;
    end else if (tick) begin
      frame_start <= mark_now;
      fcnt_q      <= (fcnt_q == CNT_W'(WORD_W - 1)) ? '0 : fcnt_q + 1'b1;
    end
  end

  generate
    if (MAX_DLY == 1) begin : g_hist_one
      always_ff @(posedge clk) begin
        if (rst)       hist_q <= '0;
        else if (tick) hist_q <= mark_now;
      end
    end else begin : g_hist_many
      always_ff @(posedge clk) begin
        if (rst)       hist_q <= '0;
        else if (tick) hist_q <= {hist_q[MAX_DLY-2:0], mark_now};
      end
    end
  endgenerate
endmodule

// File: rtl/sft_shifter.sv
// One-word holding buffer, output shift register and underrun flag.
module sft_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              tx,
  output logic              underrun
);
  logic [WORD_W-1:0] buf_q;
  logic [WORD_W-1:0] sreg_q;
  logic [WORD_W-1:0] word;
  logic              full_q;

  assign word = full_q ? buf_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q    <= '0;
      full_q   <= 1'b0;
      in_ready <= 1'b0;
      sreg_q   <= '0;
      tx       <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        buf_q    <= in_data;
        full_q   <= 1'b1;
        in_ready <= 1'b0;
      end else if (load && full_q) begin
        full_q   <= 1'b0;
        in_ready <= 1'b1;
      end else if (!full_q) begin
        in_ready <= 1'b1;
      end

      if (load) begin
        tx     <= word[WORD_W-1];
        sreg_q <= {word[WORD_W-2:0], 1'b0};
        if (!full_q) underrun <= 1'b1;
      end else if (tick) begin
        tx     <= sreg_q[WORD_W-1];
        sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sft_tx.sv
// Serial frame transmitter: internal bit clock, fixed 32-tick frames,
// data delayed 0..MAX_DLY ticks after each frame start.
module sft_tx #(
  parameter int WORD_W  = sft_pkg::SFT_WORD_W,
  parameter int CLK_DIV = sft_pkg::SFT_CLK_DIV,
  parameter int MAX_DLY = sft_pkg::SFT_MAX_DLY,
  localparam int DLY_W  = $clog2(MAX_DLY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              bit_en,
  output logic              frame_start,
  output logic              tx_data,
  output logic              underrun
);
  logic [DLY_W-1:0] dly_q;
  logic             tick;
  logic             load;

  // Delay code is captured only while reset is held; out-of-range saturates
  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= (cfg_delay > DLY_W'(MAX_DLY)) ? DLY_W'(MAX_DLY) : cfg_delay;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bit_en <= 1'b0;
    else     bit_en <= tick;
  end

  sft_bitclk #(.CLK_DIV(CLK_DIV)) u_bitclk (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  sft_framer #(.WORD_W(WORD_W), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_framer (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .dly         (dly_q),
    .frame_start (frame_start),
    .load        (load)
  );

  sft_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (load),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx       (tx_data),
    .underrun (underrun)
  );
endmodule

// File: rtl/sft_tx_chk.sv
module sft_tx_chk #(
  parameter int WORD_W = 32
) (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic frame_start,
  input logic tx_data,
  input logic underrun
);
  int   gap_q;
  logic seen_q;

  // Counts bit ticks since the last frame-start tick
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (bit_en) begin
      gap_q  <= frame_start ? 1 : gap_q + 1;
      seen_q <= seen_q | frame_start;
    end
  end

  // R1
  bit_en_single_chk: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> !bit_en);

  // R1
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |-> $stable(tx_data));

  // R1
  fs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |-> $stable(frame_start));

  // R2
  fs_period_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && frame_start && seen_q) |-> (gap_q == WORD_W));

  // R7
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!frame_start && !tx_data && !underrun && !bit_en));
endmodule

bind sft_tx sft_tx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bit_en      (bit_en),
  .frame_start (frame_start),
  .tx_data     (tx_data),
  .underrun    (underrun)
);

// File: tb/sim_sft_tx.sv
module sim_sft_tx;
  localparam int W   = 32;
  localparam int DIV = 4;
  localparam int NO_LIMIT = 100000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_delay = 2'd0;
  logic [W-1:0]  in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready, bit_en, frame_start, tx_data, underrun;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sft_tx #(.WORD_W(W), .CLK_DIV(DIV), .MAX_DLY(2)) u0 (
    .clk(clk), .rst(rst), .cfg_delay(cfg_delay), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .bit_en(bit_en),
    .frame_start(frame_start), .tx_data(tx_data), .underrun(underrun)
  );

  function automatic logic [W-1:0] wgen(int w);
    return 32'(w) * 32'h9E3779B1 + 32'h0F0F1234;
  endfunction

  task automatic chk(logic ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One run: reset with a delay code, then stream words and check every cycle
  task automatic run(int cfg, int d, int limit, int nticks, int chg_at);
    int idx = 0;
    int k = -1;
    int c = 0;
    logic pend = 1'b0;
    logic fs_e, tx_e, ur_e;
    int p;
    string tag;
    rst = 1'b1;
    cfg_delay = cfg[1:0];
    in_valid = 1'b1;
    in_data = wgen(0);
    repeat (3) begin
      @(negedge clk);
      chk(!frame_start && !tx_data && !underrun && !bit_en && !in_ready,
          "R9", {frame_start, tx_data, underrun, bit_en, in_ready}, 0);
    end
    rst = 1'b0;
    while (k < nticks - 1) begin
      @(negedge clk);
      c++;
      if (pend) begin
        chk(in_ready == 1'b0, "R6", in_ready, 0);
        idx++;
        in_valid = (idx < limit);
        in_data = wgen(idx);
        pend = 1'b0;
      end
      if (bit_en) k++;
      chk(bit_en == ((c % DIV) == 0), "R1", bit_en, (c % DIV) == 0);
      if (chg_at >= 0 && k == chg_at) cfg_delay = 2'd0;
      fs_e = (k >= 0) && ((k % W) == 0);
      chk(frame_start == fs_e, "R2", frame_start, fs_e);
      tx_e = 1'b0;
      tag = "R4";
      if (k >= 0) begin
        p = k - d;
        if (p < 0) tag = "R3";
        else if (p / W >= limit) tag = "R7";
        else begin
          tx_e = wgen(p / W)[W - 1 - (p % W)];
          if (chg_at >= 0 && k > chg_at) tag = "R8";
          else if ((p % W) >= W - d) tag = "R5";
        end
      end
      chk(tx_data == tx_e, tag, tx_data, tx_e);
      ur_e = (limit < NO_LIMIT) && (k >= limit * W + d);
      chk(underrun == ur_e, "R7", underrun, ur_e);
      if (in_valid && in_ready) pend = 1'b1;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    run(0, 0, NO_LIMIT, 5 * W, -1);   // R3 R4 R5 with no delay
    run(1, 1, NO_LIMIT, 5 * W, 40);   // R8: code changed mid-run
    run(2, 2, NO_LIMIT, 5 * W, -1);   // R5 overlap of two bits
    run(3, 2, 3, 5 * W, -1);          // R3 saturation, R7 underrun
    run(0, 0, 2, 4 * W, -1);          // R7 with no delay
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule